// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter, 24 bits wide by default, that produces a regular time base for an operating system. Software programs a reload value and enables the counter. The counter steps down once per counting tick. When it expires, it loads the reload value again, sets a sticky wrap flag and, if the interrupt option is on, sends a one-cycle request pulse to the interrupt controller. Counting ticks come either from every core clock cycle or from an external slow-tick enable pulse.

Software reaches the timer through a simple synchronous port. The port has a request strobe, a write strobe, a byte offset and 32-bit data. Read data is combinational in the cycle of the request. Read side effects take hold at the clock edge that ends the request.

Top module: `tick_timer`

## Requirements
- R1: After reset, control, reload and current value all read 0, and `irq_o` is low.
- R2: Control layout: bit 0 enable, bit 1 interrupt on wrap, bit 2 tick source (1 = every clock, 0 = `ref_tick_i`), bit 16 wrap flag. A control write (offset 0x10) updates bits 2:0 only. Write data bit 16 leaves the wrap flag unchanged.
- R3: A control read returns the current value, and the wrap flag clears at the end of the read cycle. If the counter expires in that same cycle, the flag ends up set.
- R4: Once loaded with reload value N, the counter expires on the (N+1)th counting tick, and does so again every N+1 ticks after that. Expiry sets the wrap flag. When bit 1 is set, expiry also raises `irq_o` for exactly one cycle, in the cycle after the expiring edge.
- R5: If the reload value is 0 when the counter expires, the enable bit clears and counting stops.
- R6: Any write to the current-value register (offset 0x18) reloads the counter from the reload register and clears the wrap flag.
- R7: The current-value register reads 0 while the timer is disabled. It also reads 0 while the counter sits at zero waiting for its expiring tick.
- R8: With bit 2 = 1 the counter steps every clock. With bit 2 = 0 it steps only in cycles where `ref_tick_i` is high.
- R9: A control write that changes bit 2 reloads the counter from the reload register.
- R10: The calibration register (offset 0x1C) reads 10000. The reload register (offset 0x14) keeps only its low 24 bits, and the upper bits read 0. Other offsets read 0, and writes to them change nothing.
- R11: When the enable bit goes from 0 to 1, counting resumes from the held counter value. If the held value is 0, the counter loads the reload value instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Slow reference tick enable |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | One-cycle exception request on wrap |

## Verification
Two functions can fall in the same cycle: a control read that clears the wrap flag, and counter expiry that sets it. The bench provokes this in reference-tick mode. It leaves the counter parked at zero, then raises `ref_tick_i` in the same cycle as a control read. The read must return the flag still clear. The next read must show it set, and the read after that must show it clear again. The bench also checks that the interrupt pulse fires in that cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h10;
  localparam logic [7:0] OFF_LOAD  = 8'h14;
  localparam logic [7:0] OFF_CUR   = 8'h18;
  localparam logic [7:0] OFF_CALIB = 8'h1C;
  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CALIB  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              ie_i,
  input  logic              src_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              ctrl_wr_o,
  output logic              ctrl_rd_o,
  output logic              cur_wr_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_ctrl, sel_load, sel_cur, sel_calib;
  logic [CNT_W-1:0] reload_q;
  logic [DATA_W-1:0] ctrl_word;

  assign sel_ctrl  = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_load  = addr_i == ADDR_W'(OFF_LOAD);
  assign sel_cur   = addr_i == ADDR_W'(OFF_CUR);
  assign sel_calib = addr_i == ADDR_W'(OFF_CALIB);

  assign ctrl_wr_o = req_i && we_i && sel_ctrl;
  assign ctrl_rd_o = req_i && !we_i && sel_ctrl;
  assign cur_wr_o  = req_i && we_i && sel_cur;
  assign reload_o  = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     reload_q <= '0;
    else if (req_i && we_i && sel_load) reload_q <= wdata_i[CNT_W-1:0];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_EN]   = en_i;
    ctrl_word[BIT_IE]   = ie_i;
    ctrl_word[BIT_SRC]  = src_i;
    ctrl_word[BIT_FLAG] = flag_i;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (sel_ctrl)       rdata_o = ctrl_word;
      else if (sel_load)  rdata_o = DATA_W'(reload_q);
      else if (sel_cur)   rdata_o = en_i ? DATA_W'(cnt_i) : '0;
      else if (sel_calib) rdata_o = DATA_W'(CALIB);
    end
  end

  AST_CUR_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel_cur && !en_i) |-> (rdata_o == '0)); // R7
  AST_LOAD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && sel_load) |=> $stable(reload_q)); // R10
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_rd_i,
  input  logic             cur_wr_i,
  input  logic [2:0]       ctrl_wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             en_o,
  output logic             ie_o,
  output logic             src_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic en_q, ie_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic tick, src_chg, en_rise, load, step, expire;

  assign tick    = src_q | ref_tick_i;
  assign src_chg = ctrl_wr_i && (ctrl_wdata_i[2] != src_q);
  assign en_rise = ctrl_wr_i && ctrl_wdata_i[0] && !en_q;
  assign load    = cur_wr_i || src_chg || (en_rise && cnt_q == '0);
  assign step    = en_q && tick && !load;
  assign expire  = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      src_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_wr_i) begin
        en_q  <= ctrl_wdata_i[0];
        ie_q  <= ctrl_wdata_i[1];
        src_q <= ctrl_wdata_i[2];
      end else if (expire && reload_i == '0) begin
        en_q <= 1'b0;
      end
      // set on expiry beats clear-on-read
      if (cur_wr_i)       flag_q <= 1'b0;
      else if (expire)    flag_q <= 1'b1;
      else if (ctrl_rd_i) flag_q <= 1'b0;
      irq_q <= expire && ie_q;
      if (load)        cnt_q <= reload_i;
      else if (expire) cnt_q <= reload_i;
      else if (step)   cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign src_o  = src_q;
  assign flag_o = flag_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag_q); // R4
  AST_CUR_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr_i |=> !flag_q); // R6
  AST_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && !expire && !cur_wr_i) |=> !flag_q); // R3
  AST_ZERO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload_i == '0 && !ctrl_wr_i) |=> !en_q); // R5
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_wr_i && !cur_wr_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CALIB  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic ctrl_wr, ctrl_rd, cur_wr, en, ie, src, flag;
  logic [CNT_W-1:0] reload, cnt;

  tick_timer_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CALIB(CALIB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .en_i(en), .ie_i(ie), .src_i(src),
    .flag_i(flag), .cnt_i(cnt), .ctrl_wr_o(ctrl_wr), .ctrl_rd_o(ctrl_rd),
    .cur_wr_o(cur_wr), .reload_o(reload), .rdata_o(rdata_o)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i),
    .ctrl_wr_i(ctrl_wr), .ctrl_rd_i(ctrl_rd), .cur_wr_i(cur_wr),
    .ctrl_wdata_i(wdata_i[2:0]), .reload_i(reload), .en_o(en), .ie_o(ie),
    .src_o(src), .flag_o(flag), .cnt_o(cnt), .irq_o(irq_o)
  );
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h10, A_LOAD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  function automatic logic [31:0] ctrl_val(input bit en, input bit ie, input bit src, input bit flg);
    return {15'd0, flg, 13'd0, src, ie, en};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic pulse(output logic seen);
    @(negedge clk); ref_tick = 1;
    @(negedge clk); seen = irq; ref_tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_LOAD, d); chk("R1 load", d, 0);
    rd(A_CUR, d);  chk("R1 cur", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R10 calibration, reload width, unmapped
    rd(A_CAL, d); chk("R10 calib", d, 32'd10000);
    wr(A_LOAD, 32'hFFFF_FFFF); rd(A_LOAD, d); chk("R10 load mask", d, 32'h00FF_FFFF);
    wr(8'h04, 32'h1234_5678); rd(A_LOAD, d); chk("R10 unmapped write", d, 32'h00FF_FFFF);
    rd(A_CTRL, d); chk("R10 unmapped ctrl", d, 0);
    rd(8'h00, d); chk("R10 unmapped read", d, 0);
    // R7/R8: ref tick mode, park at zero
    wr(A_LOAD, 5);
    wr(A_CTRL, 32'h3);
    wr(A_CUR, 32'hDEAD);
    idle(4); rd(A_CUR, d); chk("R8 no ref no step", d, 5);
    for (int i = 0; i < 5; i++) begin pulse(s); chk("R4 no early irq", {31'd0, s}, 0); end
    rd(A_CUR, d); chk("R7 at zero", d, 0);
    rd(A_CTRL, d); chk("R4 flag not yet", d, ctrl_val(1, 1, 0, 0));
    // R3 read and expiry in the same cycle
    @(negedge clk); req = 1; we = 0; addr = A_CTRL; ref_tick = 1;
    #1 d = rdata;
    @(negedge clk); req = 0; ref_tick = 0; s = irq;
    chk("R3 same-cycle read old", d, ctrl_val(1, 1, 0, 0));
    chk("R4 irq on expiry", {31'd0, s}, 1);
    idle(1); chk("R4 irq one cycle", {31'd0, irq}, 0);
    rd(A_CTRL, d); chk("R3 set wins", d, ctrl_val(1, 1, 0, 1));
    rd(A_CTRL, d); chk("R3 cleared by read", d, ctrl_val(1, 1, 0, 0));
    rd(A_CUR, d); chk("R4 reloaded", d, 5);
    // R6
    for (int i = 0; i < 8; i++) pulse(s);
    rd(A_CUR, d); chk("R6 pre", d, 3);
    wr(A_CUR, 32'h123); rd(A_CUR, d); chk("R6 reload", d, 5);
    rd(A_CTRL, d); chk("R6 flag clr", d, ctrl_val(1, 1, 0, 0));
    // R11 resume, R9 source change reload
    pulse(s); pulse(s);
    wr(A_CTRL, 32'h2); rd(A_CUR, d); chk("R7 disabled reads 0", d, 0);
    wr(A_CTRL, 32'h3); rd(A_CUR, d); chk("R11 resume held", d, 3);
    wr(A_CTRL, 32'h2); wr(A_CTRL, 32'h4); wr(A_CTRL, 32'h0);
    pulse(s);
    wr(A_CTRL, 32'h1); rd(A_CUR, d); chk("R9 src change reload", d, 5);
    // R5 reload zero stops
    wr(A_CTRL, 32'h3); wr(A_LOAD, 0); wr(A_CUR, 0);
    pulse(s); chk("R5 irq", {31'd0, s}, 1);
    // R2 flag unaffected by write data
    wr(A_CTRL, 32'h0000_0002);
    rd(A_CTRL, d); chk("R5 stopped, R2 flag kept", d, ctrl_val(0, 1, 0, 1));
    rd(A_CTRL, d); chk("R3 clr", d, ctrl_val(0, 1, 0, 0));
    wr(A_CTRL, 32'hFFFF_FFF8); rd(A_CTRL, d); chk("R2 only low bits", d, 0);
    pulse(s); rd(A_CUR, d); chk("R5 stays stopped", d, 0);
    // R4 random periods, core clock
    for (int k = 0; k < 8; k++) begin
      int r, n;
      r = 1 + int'($urandom_range(40));
      wr(A_CTRL, 0); wr(A_LOAD, r); wr(A_CTRL, 32'h7);
      for (int p = 0; p < 2; p++) begin
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 200);
        chk("R4 period", n, r + 1);
      end
      wr(A_CTRL, 0);
    end
    // R8 random ref tick spacing
    for (int k = 0; k < 4; k++) begin
      int r;
      r = 1 + int'($urandom_range(12));
      wr(A_CTRL, 0); wr(A_LOAD, r); wr(A_CTRL, 32'h3); wr(A_CUR, 0);
      for (int i = 1; i <= r + 1; i++) begin
        idle(int'($urandom_range(3)));
        pulse(s);
        chk("R8 ref count", {31'd0, s}, {31'd0, i == r + 1});
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule